// File: doc/BRIEF.md
# Bus Controller Response Validator

This block sits behind the word decoder of a command/response serial bus controller. Once the controller has finished sending a command, it pulses `start_i` together with the remote terminal address it commanded and the number of data words it expects back. The validator then waits for the reply. It rejects the reply if it does not begin within a bounded timeout window. It checks the status word and every data word for the right sync type and for the error flags from the decoder. It compares the status word's address field against the commanded address. It also confirms that exactly the expected number of data words arrives.

Time is measured in strobes on `tick_i`, which comes from a 1 MHz or finer time base. The timeout is `TICKS_PER_US * TIMEOUT_US` strobes, which is 20 µs by default. The end of a reply is recognised when `GAP_TICKS` strobes pass without a new word. Each reply ends with a single-cycle `done_o` pulse and a latched error vector. The error vector stays valid until the next start. The first error ends the reply at once.

Top module: `resp_validator`

## Requirements
- R1: `start_i` while idle latches `exp_addr_i` and `exp_count_i`, clears `err_o` and raises `busy_o` on the next cycle. `start_i` while busy is ignored.
- R2: If no word arrives before the `TICKS_PER_US*TIMEOUT_US`-th tick after start, `err_o[0]` (timeout) is set and `done_o` pulses. A word and a tick in the same cycle count as the word.
- R3: The first word after start is the status word and must carry command/status sync (`sync_cmd_i`=1); otherwise `err_o[1]` (sync) is set.
- R4: Every later word is a data word and must carry data sync (`sync_cmd_i`=0); otherwise `err_o[1]` is set.
- R5: A word with `manch_err_i` set is rejected (not counted) and sets `err_o[2]`.
- R6: `parity_err_i` sets `err_o[3]`; `bitcnt_err_i` sets `err_o[4]`.
- R7: If status word bits [15:11] differ from the latched address, `err_o[5]` (address) is set.
- R8: If, after the status word, fewer data words arrive than expected and `GAP_TICKS` ticks pass with no word, `err_o[6]` (count) is set.
- R9: A word that arrives after the expected count is complete, but before the gap has elapsed, sets `err_o[6]` along with any of that word's own flags.
- R10: When the expected count is reached (or the count is 0) and `GAP_TICKS` ticks then pass with no word, `done_o` pulses with `err_o` equal to 0.
- R11: Any error ends the reply: `done_o` pulses in the cycle after the offending edge, and later words change nothing until the next accepted start.
- R12: `done_o` is a one-cycle pulse, `busy_o` is low whenever `done_o` is high, and `err_o` changes only on `done_o` or on an accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Time base strobe |
| start_i | input | 1 | Command transmission finished |
| exp_addr_i | input | 5 | Commanded terminal address |
| exp_count_i | input | 6 | Expected data word count (0..32) |
| wvalid_i | input | 1 | Decoded word valid |
| sync_cmd_i | input | 1 | 1 = command/status sync, 0 = data sync |
| manch_err_i | input | 1 | Manchester error on this word |
| parity_err_i | input | 1 | Parity error on this word |
| bitcnt_err_i | input | 1 | Bit count error on this word |
| word_i | input | 16 | Decoded word |
| busy_o | output | 1 | Reply in progress |
| done_o | output | 1 | Reply finished (one cycle) |
| err_o | output | 7 | Latched error flags: 0 timeout, 1 sync, 2 manchester, 3 parity, 4 bit count, 5 address, 6 count |

## Verification
The block is tried with several kinds of reply:
- Clean replies of three data words and of zero data words. These show the success path and the status-only path apart from the count logic.
- A reply that never starts, which isolates the timeout from the gap rule.
- Status words with a wrong address or the wrong sync, and data words with the wrong sync or with decoder error flags. These show which phase applies which sync rule and that a rejected word is never counted.
- Short and overlong replies, which separate a missing word from an extra one.
- Words sent after an error and a start sent while busy, which show that the latched result is held.

// File: rtl/rv_pkg.sv
package rv_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_STATUS, PH_DATA, PH_TAIL} phase_e;
  localparam int ERR_W      = 7;
  localparam int ERR_TMO    = 0;
  localparam int ERR_SYNC   = 1;
  localparam int ERR_MANCH  = 2;
  localparam int ERR_PARITY = 3;
  localparam int ERR_BITCNT = 4;
  localparam int ERR_ADDR   = 5;
  localparam int ERR_COUNT  = 6;
endpackage

// File: rtl/rv_tick_timer.sv
module rv_tick_timer #(
  parameter int TIMEOUT_LIM = 20,
  parameter int GAP_TICKS   = 3,
  localparam int MAXV       = (TIMEOUT_LIM > GAP_TICKS) ? TIMEOUT_LIM : GAP_TICKS,
  localparam int TW         = $clog2(MAXV + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic tick_i,
  output logic timeout_hit_o,
  output logic gap_hit_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             cnt_q <= '0;
    else if (clear_i)                        cnt_q <= '0;
    else if (tick_i && cnt_q != TW'(MAXV))   cnt_q <= cnt_q + 1'b1;
  end

  assign timeout_hit_o = tick_i && (cnt_q == TW'(TIMEOUT_LIM - 1));
  assign gap_hit_o     = tick_i && (cnt_q == TW'(GAP_TICKS - 1));
endmodule

// File: rtl/rv_word_check.sv
module rv_word_check
  import rv_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              is_status_i,
  input  logic              sync_cmd_i,
  input  logic              manch_err_i,
  input  logic              parity_err_i,
  input  logic              bitcnt_err_i,
  input  logic [15:0]       word_i,
  input  logic [ADDR_W-1:0] exp_addr_i,
  output logic [ERR_W-1:0]  err_o
);
  always_comb begin
    err_o             = '0;
    err_o[ERR_SYNC]   = is_status_i ? !sync_cmd_i : sync_cmd_i;
    err_o[ERR_MANCH]  = manch_err_i;
    err_o[ERR_PARITY] = parity_err_i;
    err_o[ERR_BITCNT] = bitcnt_err_i;
    // address field sits in the top bits of the status word
    err_o[ERR_ADDR]   = is_status_i && (word_i[15 -: ADDR_W] != exp_addr_i);
  end
endmodule

// File: rtl/rv_word_counter.sv
module rv_word_counter #(
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             inc_i,
  input  logic [CNT_W-1:0] target_i,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (inc_i)   cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q + 1'b1) == target_i;
endmodule

// File: rtl/resp_validator.sv
module resp_validator
  import rv_pkg::*;
#(
  parameter int TICKS_PER_US = 1,
  parameter int TIMEOUT_US   = 20,
  parameter int GAP_TICKS    = 3,
  parameter int MAX_WORDS    = 32,
  parameter int ADDR_W       = 5,
  localparam int CNT_W       = $clog2(MAX_WORDS + 1),
  localparam int TIMEOUT_LIM = TICKS_PER_US * TIMEOUT_US
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] exp_addr_i,
  input  logic [CNT_W-1:0]  exp_count_i,
  input  logic              wvalid_i,
  input  logic              sync_cmd_i,
  input  logic              manch_err_i,
  input  logic              parity_err_i,
  input  logic              bitcnt_err_i,
  input  logic [15:0]       word_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [ERR_W-1:0]  err_o
);
  phase_e             phase_q, phase_d;
  logic [ADDR_W-1:0]  addr_q;
  logic [CNT_W-1:0]   count_q;
  logic [ERR_W-1:0]   err_q, err_d, word_err;
  logic               done_q, done_d;
  logic               accept_start, word_ok, word_seen;
  logic               tmo_hit, gap_hit, last_word;

  assign accept_start = start_i && (phase_q == PH_IDLE);
  assign word_seen    = wvalid_i && (phase_q != PH_IDLE);
  assign word_ok      = word_seen && (word_err == '0);

  rv_word_check #(.ADDR_W(ADDR_W)) u_check (
    .is_status_i (phase_q == PH_STATUS),
    .sync_cmd_i  (sync_cmd_i),
    .manch_err_i (manch_err_i),
    .parity_err_i(parity_err_i),
    .bitcnt_err_i(bitcnt_err_i),
    .word_i      (word_i),
    .exp_addr_i  (addr_q),
    .err_o       (word_err)
  );

  rv_tick_timer #(.TIMEOUT_LIM(TIMEOUT_LIM), .GAP_TICKS(GAP_TICKS)) u_timer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clear_i      (accept_start || word_seen),
    .tick_i       (tick_i),
    .timeout_hit_o(tmo_hit),
    .gap_hit_o    (gap_hit)
  );

  rv_word_counter #(.CNT_W(CNT_W)) u_count (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (accept_start),
    .inc_i   (word_ok && (phase_q == PH_DATA)),
    .target_i(count_q),
    .last_o  (last_word)
  );

  always_comb begin
    phase_d = phase_q;
    err_d   = err_q;
    done_d  = 1'b0;
    unique case (phase_q)
      PH_IDLE: if (start_i) begin
        phase_d = PH_STATUS;
        err_d   = '0;
      end
      PH_STATUS: begin
        if (wvalid_i) begin
          if (word_err != '0) begin
            err_d = word_err; done_d = 1'b1; phase_d = PH_IDLE;
          end else begin
            phase_d = (count_q == '0) ? PH_TAIL : PH_DATA;
          end
        end else if (tmo_hit) begin
          err_d[ERR_TMO] = 1'b1; done_d = 1'b1; phase_d = PH_IDLE;
        end
      end
      PH_DATA: begin
        if (wvalid_i) begin
          if (word_err != '0) begin
            err_d = word_err; done_d = 1'b1; phase_d = PH_IDLE;
          end else if (last_word) begin
            phase_d = PH_TAIL;
          end
        end else if (gap_hit) begin
          err_d[ERR_COUNT] = 1'b1; done_d = 1'b1; phase_d = PH_IDLE;
        end
      end
      PH_TAIL: begin
        if (wvalid_i) begin
          err_d = word_err;
          err_d[ERR_COUNT] = 1'b1;
          done_d = 1'b1; phase_d = PH_IDLE;
        end else if (gap_hit) begin
          done_d = 1'b1; phase_d = PH_IDLE;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      err_q   <= '0;
      done_q  <= 1'b0;
      addr_q  <= '0;
      count_q <= '0;
    end else begin
      phase_q <= phase_d;
      err_q   <= err_d;
      done_q  <= done_d;
      if (accept_start) begin
        addr_q  <= exp_addr_i;
        count_q <= exp_count_i;
      end
    end
  end

  assign busy_o = (phase_q != PH_IDLE);
  assign done_o = done_q;
  assign err_o  = err_q;
endmodule

// File: rtl/rv_checker.sv
module rv_checker #(
  parameter int ERR_W = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             start_i,
  input logic             wvalid_i,
  input logic             manch_err_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [ERR_W-1:0] err_o
);
  assert_start_clears_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o && err_o == '0));

  assert_timeout_on_tick_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o[0]) |-> $past(tick_i && !wvalid_i));

  assert_manch_from_word_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o[2]) |-> $past(wvalid_i && manch_err_i));

  assert_done_pulse_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_not_busy_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_err_held_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(err_o) |-> (done_o || $past(start_i && !busy_o)));
endmodule

bind resp_validator rv_checker #(.ERR_W(7)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .start_i    (start_i),
  .wvalid_i   (wvalid_i),
  .manch_err_i(manch_err_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .err_o      (err_o)
);

// File: tb/sim_resp_validator.sv
`timescale 1ns/1ps
module sim_resp_validator;
  localparam int TMO = 20;
  localparam int GAP = 3;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        tick = 1'b0, start = 1'b0, wvalid = 1'b0, sync = 1'b0;
  logic        manch = 1'b0, par = 1'b0, bcnt = 1'b0;
  logic [4:0]  eaddr = '0;
  logic [5:0]  ecnt = '0;
  logic [15:0] word = '0;
  logic        busy, done;
  logic [6:0]  err;

  int vectors = 0, miscompares = 0;
  bit finished = 0;
  string cur_req = "R12";

  always #2 clk = ~clk;

  resp_validator u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .start_i(start),
    .exp_addr_i(eaddr), .exp_count_i(ecnt), .wvalid_i(wvalid),
    .sync_cmd_i(sync), .manch_err_i(manch), .parity_err_i(par),
    .bitcnt_err_i(bcnt), .word_i(word), .busy_o(busy), .done_o(done), .err_o(err)
  );

  // reference model: 0 idle, 1 awaiting status, 2 data, 3 after last word
  int        m_ph = 0, m_ticks = 0, m_rx = 0, m_exp = 0;
  logic [4:0] m_addr = '0;
  logic [6:0] m_err = '0;
  logic       m_done = 1'b0;

  function automatic logic [6:0] word_flags(bit is_status);
    logic [6:0] f = '0;
    f[1] = is_status ? !sync : sync;
    f[2] = manch; f[3] = par; f[4] = bcnt;
    f[5] = is_status && (word[15:11] != m_addr);
    return f;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_ticks = 0; m_rx = 0; m_exp = 0; m_addr = '0; m_err = '0; m_done = 0;
    end else begin
      logic [6:0] f;
      m_done = 0;
      case (m_ph)
        0: if (start) begin
          m_ph = 1; m_addr = eaddr; m_exp = ecnt; m_err = '0; m_ticks = 0; m_rx = 0;
        end
        1: if (wvalid) begin
          f = word_flags(1); m_ticks = 0;
          if (f != 0) begin m_err = f; m_done = 1; m_ph = 0; end
          else m_ph = (m_exp == 0) ? 3 : 2;
        end else if (tick) begin
          m_ticks++;
          if (m_ticks == TMO) begin m_err[0] = 1; m_done = 1; m_ph = 0; end
        end
        2: if (wvalid) begin
          f = word_flags(0); m_ticks = 0;
          if (f != 0) begin m_err = f; m_done = 1; m_ph = 0; end
          else begin m_rx++; if (m_rx == m_exp) m_ph = 3; end
        end else if (tick) begin
          m_ticks++;
          if (m_ticks == GAP) begin m_err[6] = 1; m_done = 1; m_ph = 0; end
        end
        3: if (wvalid) begin
          m_err = word_flags(0); m_err[6] = 1; m_done = 1; m_ph = 0;
        end else if (tick) begin
          m_ticks++;
          if (m_ticks == GAP) begin m_done = 1; m_ph = 0; end
        end
        default: m_ph = 0;
      endcase
    end
  end

  always @(posedge clk) begin
    #1;
    if (rst_n && !finished) begin
      vectors++;
      if (done !== m_done || err !== m_err || busy !== (m_ph != 0)) begin
        miscompares++;
        $display("FAIL %s: done=%0b err=%07b busy=%0b expected done=%0b err=%07b busy=%0b",
                 cur_req, done, err, busy, m_done, m_err, m_ph != 0);
      end
    end
  end

  initial begin : tick_gen
    int tc = 0;
    forever begin
      @(negedge clk);
      tick = (tc % 4 == 0);
      tc++;
    end
  end

  task automatic do_start(input logic [4:0] a, input logic [5:0] n);
    @(negedge clk); start = 1; eaddr = a; ecnt = n;
    @(negedge clk); start = 0; eaddr = '0; ecnt = '0;
  endtask

  task automatic send(input logic [15:0] w, input bit s, input bit m, input bit p, input bit b);
    @(negedge clk); wvalid = 1; word = w; sync = s; manch = m; par = p; bcnt = b;
    @(negedge clk); wvalid = 0; word = '0; sync = 0; manch = 0; par = 0; bcnt = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic pause(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
    end
  end

  initial begin : stim
    pause(3);
    rst_n = 1;
    cur_req = "R12"; pause(4);                       // reset state: idle, no errors
    // R10 clean reply, three data words; R1 start while busy is ignored
    cur_req = "R10"; do_start(5'd5, 6'd3);
    cur_req = "R1";  do_start(5'd9, 6'd1);
    cur_req = "R10"; send({5'd5, 11'h123}, 1, 0, 0, 0);
    send(16'hAAAA, 0, 0, 0, 0); send(16'h5555, 0, 0, 0, 0); send(16'h0F0F, 0, 0, 0, 0);
    pause(30);
    // R10 status-only reply
    do_start(5'd31, 6'd0); send({5'd31, 11'h0}, 1, 0, 0, 0); pause(30);
    // R2 no reply at all
    cur_req = "R2"; do_start(5'd3, 6'd2); pause(110);
    // R7 wrong address
    cur_req = "R7"; do_start(5'd3, 6'd2); send({5'd4, 11'h0}, 1, 0, 0, 0); pause(6);
    // R3 status with data sync
    cur_req = "R3"; do_start(5'd3, 6'd2); send({5'd3, 11'h0}, 0, 0, 0, 0); pause(6);
    // R4 data word with command sync
    cur_req = "R4"; do_start(5'd3, 6'd2); send({5'd3, 11'h0}, 1, 0, 0, 0);
    send(16'h1234, 1, 0, 0, 0); pause(6);
    // R5 manchester error on data word, then R11 further words ignored
    cur_req = "R5"; do_start(5'd7, 6'd2); send({5'd7, 11'h0}, 1, 0, 0, 0);
    send(16'h1111, 0, 1, 0, 0);
    cur_req = "R11"; send(16'h2222, 0, 0, 0, 0); send({5'd7, 11'h0}, 1, 0, 0, 0); pause(30);
    // R6 parity on status, bit count on data
    cur_req = "R6"; do_start(5'd2, 6'd1); send({5'd2, 11'h0}, 1, 0, 1, 0); pause(6);
    do_start(5'd2, 6'd1); send({5'd2, 11'h0}, 1, 0, 0, 0); send(16'h3333, 0, 0, 0, 1); pause(6);
    // R8 short reply
    cur_req = "R8"; do_start(5'd12, 6'd3); send({5'd12, 11'h0}, 1, 0, 0, 0);
    send(16'h4444, 0, 0, 0, 0); pause(30);
    // R9 one word too many, with its own parity flag
    cur_req = "R9"; do_start(5'd12, 6'd1); send({5'd12, 11'h0}, 1, 0, 0, 0);
    send(16'h5555, 0, 0, 0, 0); send(16'h6666, 0, 0, 1, 0); pause(30);
    // R9 extra word on zero-count reply
    do_start(5'd1, 6'd0); send({5'd1, 11'h0}, 1, 0, 0, 0); send(16'h7777, 0, 0, 0, 0); pause(6);
    // R12 restart after an error and clean completion
    cur_req = "R12"; do_start(5'd6, 6'd1); send({5'd6, 11'h0}, 1, 0, 0, 0);
    send(16'h8888, 0, 0, 0, 0); pause(30);
    finish_run();
  end
endmodule